// File: doc/BRIEF.md
# Parallel Display Bus Bridge

This block links an on-chip request port to an external display controller that speaks an asynchronous 8080-style parallel protocol. Each request carries a byte address, a write flag, a width flag (one byte or a full 16-bit word) and write data. A request that decodes inside the enabled 64 MiB region of the external bank becomes one timed bus cycle. That cycle drives an active-low chip select, an active-low write or read strobe, a 16-bit data bus and a halfword address.

Software picks the register-select level by its choice of address. The display's register-select input is wired to external address pin 16. An access at bank base plus 0x20000 selects the controller's registers, and an access at the bank base selects its data port. The setup and strobe lengths come from two configuration inputs. These are captured when a request is accepted, so the bus timing can be matched to the attached panel.

The data bus is presented as separate output, output-enable and input signals. The pad ring above this block joins them into one bidirectional pin set.

Top module: `pdb_bridge`

## Requirements
- R1: After reset and whenever `req_ready` is high, `bus_cs_n`, `bus_we_n` and `bus_re_n` are high, `bus_dq_oe` is low and `rsp_valid` is low.
- R2: A request hits only if `req_addr[31:28]` equals 4'h6 and `req_addr[27:26]` equals `cfg_region`. Region 1 at 0x60000000 is code 0, and region 4 at base plus 0x0C000000 is code 3. A hit pulls `bus_cs_n` low in the cycle after acceptance.
- R3: A request that misses is accepted and answered in the next cycle with `rsp_valid`=1 and `rsp_err`=1. Chip select and both strobes stay high throughout.
- R4: For the whole access, `bus_addr` equals `req_addr[25:1]`, so an access at bank base plus 0x20000 drives `bus_addr[16]` (register select) high.
- R5: A hit holds `bus_cs_n` low for (`cfg_addset`+1)+(strobe length) cycles. The first `cfg_addset`+1 of those cycles have both strobes high, and `cfg_addset` ranges over 0 to 15.
- R6: The strobe (data phase) lasts `cfg_datast`+1 cycles for `cfg_datast` from 1 to 255, and a `cfg_datast` of 0 gives the same 2 cycles as 1.
- R7: On a write, `bus_dq_oe` is high for every chip-select-low cycle, and only `bus_we_n` strobes. A wide write drives `req_wdata`. A narrow write puts `req_wdata[7:0]` on bits 15:8 when `req_addr[0]`=1, or on bits 7:0 when `req_addr[0]`=0, and the other byte is zero.
- R8: On a read, `bus_dq_oe` stays low and only `bus_re_n` strobes. `rsp_rdata` holds `bus_dq_i` as sampled in the last strobe cycle. A narrow read returns the lane picked by `req_addr[0]` (1 = bits 15:8) zero-extended.
- R9: An access ends with `bus_cs_n` high and a single-cycle `rsp_valid` with `rsp_err`=0. `req_ready` stays low in that cycle and rises in the next.
- R10: A change on `cfg_addset`, `cfg_datast` or `cfg_region` after acceptance has no effect on the access in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_addset | input | 4 | Address-setup length minus one |
| cfg_datast | input | 8 | Strobe length minus one (0 acts as 1) |
| cfg_region | input | 2 | Enabled region code within the bank |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Bridge idle and able to accept |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wide | input | 1 | 1 = 16-bit access, 0 = byte access |
| req_addr | input | 32 | Byte address |
| req_wdata | input | 16 | Write data |
| rsp_valid | output | 1 | Access finished (one-cycle pulse) |
| rsp_err | output | 1 | Request missed the enabled region |
| rsp_rdata | output | 16 | Captured read data |
| bus_cs_n | output | 1 | Chip select, active low |
| bus_we_n | output | 1 | Write strobe, active low |
| bus_re_n | output | 1 | Read strobe, active low |
| bus_addr | output | 25 | Halfword address pins A0..A24 (A16 = register select) |
| bus_dq_o | output | 16 | Data bus output value |
| bus_dq_oe | output | 1 | Data bus output enable |
| bus_dq_i | input | 16 | Data bus input value |

## Verification
The completion pulse of one access can coincide with a new request already waiting on the request port. The bench creates this overlap by holding `req_valid` high across the end of a write. It then checks that the response cycle shows `req_ready` low with chip select high, that the next cycle is idle with `req_ready` high, and that chip select falls only one cycle after that. A second overlap places a configuration change in the cycle right after acceptance, and the measured setup and strobe lengths must match the values held when the request was accepted.

// File: rtl/pdb_pkg.sv
package pdb_pkg;

    typedef enum logic [1:0] {
        PDB_IDLE  = 2'd0,
        PDB_SETUP = 2'd1,
        PDB_DATA  = 2'd2,
        PDB_DONE  = 2'd3
    } pdb_state_e;

endpackage

// File: rtl/pdb_decode.sv
// Region match, byte-to-pin address shift and write lane placement.
module pdb_decode #(
    parameter int          ADDR_W      = 32,
    parameter logic [31:0] BANK_BASE   = 32'h6000_0000,
    parameter int          BANK_BITS   = 28,
    parameter int          REGION_BITS = 2,
    parameter int          BYTE_SHIFT  = 1,
    parameter int          DW          = 16,
    localparam int         REGION_LSB  = BANK_BITS - REGION_BITS,
    localparam int         EXT_AW      = REGION_LSB - BYTE_SHIFT
) (
    input  logic [ADDR_W-1:0]      addr,
    input  logic [REGION_BITS-1:0] region,
    input  logic                   wide,
    input  logic [DW-1:0]          wdata,
    output logic                   hit,
    output logic [EXT_AW-1:0]      ext_addr,
    output logic                   lane_hi,
    output logic [DW-1:0]          dq_w
);
    localparam int HALF = DW / 2;

    always_comb begin
        hit = (addr[ADDR_W-1:BANK_BITS] == BANK_BASE[ADDR_W-1:BANK_BITS]) &&
              (addr[BANK_BITS-1:REGION_LSB] == region);
    end

    assign ext_addr = addr[REGION_LSB-1:BYTE_SHIFT];

    generate
        if (BYTE_SHIFT == 1) begin : g_halfword_bus
            assign lane_hi = addr[0];
            always_comb begin
                if (wide)
                    dq_w = wdata;
                else if (addr[0])
                    dq_w = {wdata[HALF-1:0], {HALF{1'b0}}};
                else
                    dq_w = {{HALF{1'b0}}, wdata[HALF-1:0]};
            end
        end else begin : g_byte_bus
            assign lane_hi = 1'b0;
            always_comb begin
                dq_w = wide ? wdata : {{HALF{1'b0}}, wdata[HALF-1:0]};
            end
        end
    endgenerate

endmodule

// File: rtl/pdb_seq.sv
// Strobe sequencer: setup phase, strobe phase, one idle completion cycle.
module pdb_seq
    import pdb_pkg::*;
#(
    parameter int EXT_AW = 25,
    parameter int DW     = 16,
    parameter int SET_W  = 4,
    parameter int CNT_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc,
    input  logic              hit,
    input  logic              write,
    input  logic              wide,
    input  logic              lane_hi,
    input  logic [EXT_AW-1:0] ext_addr,
    input  logic [DW-1:0]     dq_w,
    input  logic [SET_W-1:0]  addset,
    input  logic [CNT_W-1:0]  datast,
    input  logic [DW-1:0]     dq_i,
    output logic              ready,
    output logic              cs_n,
    output logic              we_n,
    output logic              re_n,
    output logic              oe,
    output logic [EXT_AW-1:0] addr,
    output logic [DW-1:0]     dq_o,
    output logic              rsp,
    output logic              err,
    output logic [DW-1:0]     rdata
);
    localparam int HALF = DW / 2;
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    typedef struct packed {
        pdb_state_e        st;
        logic [CNT_W-1:0]  cnt;
        logic [CNT_W-1:0]  dlen;
        logic              wr;
        logic              narrow;
        logic              lane_hi;
        logic              cs_n;
        logic              we_n;
        logic              re_n;
        logic              oe;
        logic [EXT_AW-1:0] addr;
        logic [DW-1:0]     dq;
        logic              rsp;
        logic              err;
        logic [DW-1:0]     rdata;
    } seq_t;

    seq_t seq_d, seq_q;
    logic [DW-1:0] cap_d;

    always_comb begin
        if (!seq_q.narrow)
            cap_d = dq_i;
        else if (seq_q.lane_hi)
            cap_d = {{HALF{1'b0}}, dq_i[DW-1:HALF]};
        else
            cap_d = {{HALF{1'b0}}, dq_i[HALF-1:0]};
    end

    always_comb begin
        seq_d     = seq_q;
        seq_d.rsp = 1'b0;
        unique case (seq_q.st)
            PDB_IDLE: begin
                if (acc) begin
                    if (hit) begin
                        seq_d.st      = PDB_SETUP;
                        seq_d.cnt     = CNT_W'(addset);
                        seq_d.dlen    = (datast == '0) ? ONE : datast;
                        seq_d.wr      = write;
                        seq_d.narrow  = !wide;
                        seq_d.lane_hi = lane_hi;
                        seq_d.addr    = ext_addr;
                        seq_d.dq      = dq_w;
                        seq_d.cs_n    = 1'b0;
                        seq_d.oe      = write;
                        seq_d.err     = 1'b0;
                    end else begin
                        seq_d.st    = PDB_DONE;
                        seq_d.rsp   = 1'b1;
                        seq_d.err   = 1'b1;
                        seq_d.rdata = '0;
                    end
                end
            end
            PDB_SETUP: begin
                if (seq_q.cnt == '0) begin
                    seq_d.st   = PDB_DATA;
                    seq_d.cnt  = seq_q.dlen;
                    seq_d.we_n = !seq_q.wr;
                    seq_d.re_n = seq_q.wr;
                end else begin
                    seq_d.cnt = seq_q.cnt - ONE;
                end
            end
            PDB_DATA: begin
                if (seq_q.cnt == '0) begin
                    seq_d.st    = PDB_DONE;
                    seq_d.cs_n  = 1'b1;
                    seq_d.we_n  = 1'b1;
                    seq_d.re_n  = 1'b1;
                    seq_d.oe    = 1'b0;
                    seq_d.rsp   = 1'b1;
                    seq_d.err   = 1'b0;
                    seq_d.rdata = seq_q.wr ? '0 : cap_d;
                end else begin
                    seq_d.cnt = seq_q.cnt - ONE;
                end
            end
            PDB_DONE: begin
                seq_d.st = PDB_IDLE;
            end
            default: begin
                seq_d.st = PDB_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q         <= '0;
            seq_q.st      <= PDB_IDLE;
            seq_q.cs_n    <= 1'b1;
            seq_q.we_n    <= 1'b1;
            seq_q.re_n    <= 1'b1;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign ready = (seq_q.st == PDB_IDLE);
    assign cs_n  = seq_q.cs_n;
    assign we_n  = seq_q.we_n;
    assign re_n  = seq_q.re_n;
    assign oe    = seq_q.oe;
    assign addr  = seq_q.addr;
    assign dq_o  = seq_q.dq;
    assign rsp   = seq_q.rsp;
    assign err   = seq_q.err;
    assign rdata = seq_q.rdata;

endmodule

// File: rtl/pdb_bridge.sv
module pdb_bridge #(
    parameter int          ADDR_W      = 32,
    parameter logic [31:0] BANK_BASE   = 32'h6000_0000,
    parameter int          BANK_BITS   = 28,
    parameter int          REGION_BITS = 2,
    parameter int          BYTE_SHIFT  = 1,
    parameter int          DW          = 16,
    parameter int          SET_W       = 4,
    parameter int          CNT_W       = 8,
    localparam int         EXT_AW      = BANK_BITS - REGION_BITS - BYTE_SHIFT
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [SET_W-1:0]       cfg_addset,
    input  logic [CNT_W-1:0]       cfg_datast,
    input  logic [REGION_BITS-1:0] cfg_region,
    input  logic                   req_valid,
    output logic                   req_ready,
    input  logic                   req_write,
    input  logic                   req_wide,
    input  logic [ADDR_W-1:0]      req_addr,
    input  logic [DW-1:0]          req_wdata,
    output logic                   rsp_valid,
    output logic                   rsp_err,
    output logic [DW-1:0]          rsp_rdata,
    output logic                   bus_cs_n,
    output logic                   bus_we_n,
    output logic                   bus_re_n,
    output logic [EXT_AW-1:0]      bus_addr,
    output logic [DW-1:0]          bus_dq_o,
    output logic                   bus_dq_oe,
    input  logic [DW-1:0]          bus_dq_i
);
    logic              req_hit;
    logic [EXT_AW-1:0] dec_addr;
    logic              dec_lane_hi;
    logic [DW-1:0]     dec_dq;
    logic              req_acc;

    assign req_acc = req_valid && req_ready;

    pdb_decode #(
        .ADDR_W      (ADDR_W),
        .BANK_BASE   (BANK_BASE),
        .BANK_BITS   (BANK_BITS),
        .REGION_BITS (REGION_BITS),
        .BYTE_SHIFT  (BYTE_SHIFT),
        .DW          (DW)
    ) u_decode (
        .addr     (req_addr),
        .region   (cfg_region),
        .wide     (req_wide),
        .wdata    (req_wdata),
        .hit      (req_hit),
        .ext_addr (dec_addr),
        .lane_hi  (dec_lane_hi),
        .dq_w     (dec_dq)
    );

    pdb_seq #(
        .EXT_AW (EXT_AW),
        .DW     (DW),
        .SET_W  (SET_W),
        .CNT_W  (CNT_W)
    ) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .acc      (req_acc),
        .hit      (req_hit),
        .write    (req_write),
        .wide     (req_wide),
        .lane_hi  (dec_lane_hi),
        .ext_addr (dec_addr),
        .dq_w     (dec_dq),
        .addset   (cfg_addset),
        .datast   (cfg_datast),
        .dq_i     (bus_dq_i),
        .ready    (req_ready),
        .cs_n     (bus_cs_n),
        .we_n     (bus_we_n),
        .re_n     (bus_re_n),
        .oe       (bus_dq_oe),
        .addr     (bus_addr),
        .dq_o     (bus_dq_o),
        .rsp      (rsp_valid),
        .err      (rsp_err),
        .rdata    (rsp_rdata)
    );

endmodule

// File: rtl/pdb_chk.sv
module pdb_chk #(
    parameter int EXT_AW = 25
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic              hit,
    input logic              bus_cs_n,
    input logic              bus_we_n,
    input logic              bus_re_n,
    input logic              bus_dq_oe,
    input logic [EXT_AW-1:0] bus_addr,
    input logic              rsp_valid,
    input logic              rsp_err
);
    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (bus_cs_n && bus_we_n && bus_re_n && !bus_dq_oe));

    // R2
    hit_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && hit) |=> !bus_cs_n);

    // R3
    miss_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && !hit) |=> (rsp_valid && rsp_err && bus_cs_n));

    // R3
    err_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_err) |-> (bus_cs_n && $past(bus_cs_n)));

    // R4
    addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_cs_n && !$past(bus_cs_n)) |-> $stable(bus_addr));

    // R5
    strobe_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_we_n || !bus_re_n) |-> (!bus_cs_n && (bus_we_n || bus_re_n)));

    // R7
    write_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_we_n |-> bus_dq_oe);

    // R8
    read_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_re_n |-> !bus_dq_oe);

    // R9
    gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_cs_n) |-> (rsp_valid && !rsp_err && !req_ready));

    // R9
    ready_after_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> (req_ready && !rsp_valid));

endmodule

bind pdb_bridge pdb_chk #(.EXT_AW(EXT_AW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .hit       (req_hit),
    .bus_cs_n  (bus_cs_n),
    .bus_we_n  (bus_we_n),
    .bus_re_n  (bus_re_n),
    .bus_dq_oe (bus_dq_oe),
    .bus_addr  (bus_addr),
    .rsp_valid (rsp_valid),
    .rsp_err   (rsp_err)
);

// File: tb/sim_pdb_bridge.sv
`timescale 1ns/1ps
module sim_pdb_bridge;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  cfg_addset = '0;
    logic [7:0]  cfg_datast = 8'd1;
    logic [1:0]  cfg_region = '0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_write = 1'b0;
    logic        req_wide = 1'b1;
    logic [31:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic        rsp_valid, rsp_err;
    logic [15:0] rsp_rdata;
    logic        bus_cs_n, bus_we_n, bus_re_n, bus_dq_oe;
    logic [24:0] bus_addr;
    logic [15:0] bus_dq_o, bus_dq_i;
    logic [15:0] panel = '0;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;

    always #5 clk = ~clk;

    // panel drives its value only while the read strobe is low
    assign bus_dq_i = !bus_re_n ? panel : 16'hDEAD;

    pdb_bridge u0 (
        .clk(clk), .rst_n(rst_n),
        .cfg_addset(cfg_addset), .cfg_datast(cfg_datast), .cfg_region(cfg_region),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_wide(req_wide), .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
        .bus_cs_n(bus_cs_n), .bus_we_n(bus_we_n), .bus_re_n(bus_re_n),
        .bus_addr(bus_addr), .bus_dq_o(bus_dq_o), .bus_dq_oe(bus_dq_oe),
        .bus_dq_i(bus_dq_i)
    );

    typedef struct packed {
        logic        wr;
        logic        wide;
        logic [31:0] addr;
        logic [15:0] wdata;
        logic [3:0]  aset;
        logic [7:0]  dset;
        logic [1:0]  region;
        logic [15:0] pval;
        logic        err;
        logic [24:0] xaddr;
        logic [15:0] xdq;
        logic [15:0] xrd;
    } vec_t;

    localparam int NV = 11;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 1'b1, 32'h6000_0000, 16'h1234, 4'd0,  8'd1,   2'd0, 16'h0000, 1'b0, 25'h0000000, 16'h1234, 16'h0000},
        '{1'b1, 1'b1, 32'h6002_0000, 16'hBEEF, 4'd2,  8'd3,   2'd0, 16'h0000, 1'b0, 25'h0010000, 16'hBEEF, 16'h0000},
        '{1'b0, 1'b1, 32'h6000_0010, 16'h0000, 4'd1,  8'd2,   2'd0, 16'hA5C3, 1'b0, 25'h0000008, 16'h0000, 16'hA5C3},
        '{1'b1, 1'b0, 32'h6000_0003, 16'h007E, 4'd0,  8'd1,   2'd0, 16'h0000, 1'b0, 25'h0000001, 16'h7E00, 16'h0000},
        '{1'b0, 1'b0, 32'h6000_0005, 16'h0000, 4'd3,  8'd1,   2'd0, 16'h9A4B, 1'b0, 25'h0000002, 16'h0000, 16'h009A},
        '{1'b1, 1'b1, 32'h6400_0000, 16'h1111, 4'd0,  8'd1,   2'd0, 16'h0000, 1'b1, 25'h0000000, 16'h0000, 16'h0000},
        '{1'b1, 1'b1, 32'h6C00_0004, 16'h55AA, 4'd0,  8'd0,   2'd3, 16'h0000, 1'b0, 25'h0000002, 16'h55AA, 16'h0000},
        '{1'b0, 1'b1, 32'h6000_0000, 16'h0000, 4'd0,  8'd1,   2'd3, 16'h0000, 1'b1, 25'h0000000, 16'h0000, 16'h0000},
        '{1'b1, 1'b1, 32'h7000_0000, 16'h2222, 4'd0,  8'd1,   2'd0, 16'h0000, 1'b1, 25'h0000000, 16'h0000, 16'h0000},
        '{1'b0, 1'b1, 32'h63FF_FFFE, 16'h0000, 4'd15, 8'd255, 2'd0, 16'h0F0F, 1'b0, 25'h1FFFFFF, 16'h0000, 16'h0F0F},
        '{1'b1, 1'b0, 32'h6000_0002, 16'hFF11, 4'd1,  8'd1,   2'd0, 16'h0000, 1'b0, 25'h0000001, 16'h0011, 16'h0000}
    };

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    endtask

    // runs one access; cfg changes to chg_* right after acceptance when chg=1
    task automatic run_one(input vec_t v, input bit chg,
                           input logic [3:0] chg_a, input logic [7:0] chg_d);
        int cs_cnt = 0;
        int st_cnt = 0;
        int oe_bad = 0;
        int dq_bad = 0;
        int guard = 0;
        int dlen;
        int exp_cs;
        int exp_st;
        logic [24:0] first_addr = '0;
        logic [24:0] addr_last = '0;
        bit addr_moved = 1'b0;
        bit strobe_wrong = 1'b0;
        dlen   = (v.dset == 0) ? 1 : int'(v.dset);
        exp_st = v.err ? 0 : dlen + 1;
        exp_cs = v.err ? 0 : int'(v.aset) + 1 + exp_st;
        @(negedge clk);
        cfg_addset = v.aset;
        cfg_datast = v.dset;
        cfg_region = v.region;
        req_write  = v.wr;
        req_wide   = v.wide;
        req_addr   = v.addr;
        req_wdata  = v.wdata;
        panel      = v.pval;
        req_valid  = 1'b1;
        chk(req_ready == 1'b1, "R1", "ready before request", 32'(req_ready), 32'd1);
        @(negedge clk);
        req_valid = 1'b0;
        if (chg) begin
            cfg_addset = chg_a;
            cfg_datast = chg_d;
            cfg_region = ~v.region;
        end
        while (!rsp_valid && guard < 2000) begin
            if (!bus_cs_n) begin
                if (cs_cnt == 0) first_addr = bus_addr;
                else if (bus_addr != addr_last) addr_moved = 1'b1;
                addr_last = bus_addr;
                cs_cnt++;
                if (bus_dq_oe != v.wr) oe_bad++;
            end
            if (!bus_we_n || !bus_re_n) begin
                st_cnt++;
                if (v.wr ? !bus_re_n : !bus_we_n) strobe_wrong = 1'b1;
            end
            if (!bus_we_n && bus_dq_o != v.xdq) dq_bad++;
            @(negedge clk);
            guard++;
        end
        chk(rsp_valid == 1'b1, "R9", "response seen", 32'(rsp_valid), 32'd1);
        if (v.err) begin
            chk(guard == 0, "R3", "error response latency", 32'(guard), 32'd0);
            chk(rsp_err == 1'b1, "R3", "error flag", 32'(rsp_err), 32'd1);
            chk(cs_cnt == 0 && st_cnt == 0, "R3", "bus quiet on miss",
                32'(cs_cnt + st_cnt), 32'd0);
        end else begin
            chk(rsp_err == 1'b0, "R2", "hit not flagged", 32'(rsp_err), 32'd0);
            chk(cs_cnt == exp_cs, "R5", "chip select cycles", 32'(cs_cnt), 32'(exp_cs));
            chk(cs_cnt - st_cnt == int'(v.aset) + 1, "R5", "setup cycles",
                32'(cs_cnt - st_cnt), 32'(int'(v.aset) + 1));
            chk(st_cnt == exp_st, "R6", "strobe cycles", 32'(st_cnt), 32'(exp_st));
            chk(first_addr == v.xaddr && !addr_moved, "R4", "external address",
                32'(first_addr), 32'(v.xaddr));
            chk(!strobe_wrong, "R7", "only the matching strobe moves",
                32'(strobe_wrong), 32'd0);
            if (v.wr) begin
                chk(oe_bad == 0, "R7", "write drive enable", 32'(oe_bad), 32'd0);
                chk(dq_bad == 0, "R7", "write data lanes", 32'(dq_bad), 32'd0);
            end else begin
                chk(oe_bad == 0, "R8", "read bus released", 32'(oe_bad), 32'd0);
                chk(rsp_rdata == v.xrd, "R8", "read data", 32'(rsp_rdata), 32'(v.xrd));
            end
        end
        chk(!req_ready && bus_cs_n, "R9", "no ready in response cycle",
            32'({req_ready, bus_cs_n}), 32'b01);
        @(negedge clk);
        chk(req_ready && !rsp_valid, "R9", "ready after response",
            32'({req_ready, rsp_valid}), 32'b10);
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cyc++;
            if (cyc > 100000) begin
                n_chk++;
                n_bad++;
                $display("FAIL watchdog: actual=%0d expected<=%0d", cyc, 100000);
                finish_run();
            end
        end
    end

    initial begin
        vec_t w;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(bus_cs_n && bus_we_n && bus_re_n && !bus_dq_oe, "R1", "bus idle in reset",
            32'({bus_cs_n, bus_we_n, bus_re_n, bus_dq_oe}), 32'b1110);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready && !rsp_valid && bus_cs_n, "R1", "idle after reset",
            32'({req_ready, rsp_valid, bus_cs_n}), 32'b101);

        for (int i = 0; i < NV; i++) begin
            run_one(VECS[i], 1'b0, 4'd0, 8'd0);
        end

        // R10: configuration changed right after acceptance
        w = VECS[0];
        w.aset = 4'd0;
        w.dset = 8'd4;
        run_one(w, 1'b1, 4'd15, 8'd255);

        // R9 / R2: request held valid across the end of an access
        @(negedge clk);
        cfg_addset = 4'd0; cfg_datast = 8'd1; cfg_region = 2'd0;
        req_write = 1'b1; req_wide = 1'b1; req_addr = 32'h6000_0000;
        req_wdata = 16'hC0DE; req_valid = 1'b1;
        begin
            int g = 0;
            @(negedge clk);
            while (!rsp_valid && g < 100) begin
                @(negedge clk);
                g++;
            end
        end
        chk(!req_ready && bus_cs_n, "R9", "overlap: response cycle busy",
            32'({req_ready, bus_cs_n}), 32'b01);
        @(negedge clk);
        chk(req_ready && bus_cs_n, "R9", "overlap: idle cycle",
            32'({req_ready, bus_cs_n}), 32'b11);
        @(negedge clk);
        req_valid = 1'b0;
        chk(!bus_cs_n, "R2", "overlap: second access starts", 32'(bus_cs_n), 32'd0);
        begin
            int g = 0;
            while (!rsp_valid && g < 100) begin
                @(negedge clk);
                g++;
            end
        end
        @(negedge clk);
        chk(req_ready && bus_cs_n, "R1", "idle at end", 32'({req_ready, bus_cs_n}), 32'b11);

        finish_run();
    end

endmodule